// File: doc/BRIEF.md
# Two-Level Interrupt Controller

This block arbitrates the interrupt requests of an 8-bit microcontroller core. Five request lines come from peripherals outside the block: two external pins, two timer overflows and a serial port. The serial port contributes a receive flag and a transmit flag, which share one request line. A per-source enable register gates each line. One global enable bit overrides all of them, and a per-source priority register places each line in either a high or a low level. The core reaches both registers through a simple special-function-register port with an 8-bit address.

The core pulses `sampleStb` at the fixed point of each machine cycle where request flags are valid. On that edge the block copies the request lines into a snapshot, and it arbitrates on that snapshot during the following cycle. When a request wins, the block raises `takeIrq` for one cycle. It presents the vector address of the winner and pulses a clear strobe for the winning flag, except for the serial source, whose flags software must clear. The block also records which priority level is in service, so that a low-level routine can be preempted but a high-level routine cannot. The core pulses `retiStb` on return from interrupt, which releases the innermost active level.

Top module: `irq_two_level`

## Requirements
- R1: After reset, `takeIrq` is 0, `actLevel` is 00, `vecAddr` is 0000h, `clrFlags` is 0000, and reads of address A8h and B8h both return 00h.
- R2: At A8h the enable register has the global enable in bit 7 and the source enables in bits 4..0: external 0 in bit 0, timer 0 in bit 1, external 1 in bit 2, timer 1 in bit 3, serial in bit 4. Bits 6 and 5 read as 0. At B8h the priority register uses bits 4..0 in the same source order, where 1 means high, and bits 7..5 read as 0. Other addresses read as 00h, and writes to them change neither register.
- R3: While the global enable is 0, no request is taken. While it is 1, a source is taken only if its own enable bit is 1.
- R4: Request lines are observed only on a clock edge where `sampleStb` is 1. A request that appears and goes away between sample edges is never taken. `takeIrq` is 0 in the cycle after the sampling edge and becomes 1 one edge later, for exactly one cycle.
- R5: Within one level, ties are broken in the order external 0, timer 0, external 1, timer 1, serial. These sources use the vectors 0003h, 000Bh, 0013h, 001Bh and 0023h respectively.
- R6: An eligible high-priority request wins over any low-priority request, whatever their places in the tie-break order.
- R7: While a low-level routine is active (`actLevel` bit 0), low requests are not taken, but a high request is taken and sets `actLevel` bit 1. While a high-level routine is active (`actLevel` bit 1), nothing is taken.
- R8: A pulse on `retiStb` clears `actLevel` bit 1 if that bit is set, and otherwise clears bit 0.
- R9: The serial receive and transmit inputs each raise the serial request on their own and are taken at vector 0023h with `clrFlags` all 0. For any other source, `clrFlags` bit i (where i is the source index from R2) pulses together with `takeIrq`.
- R10: `vecAddr` keeps its last value in every cycle where `takeIrq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleStb | input | 1 | Samples the request lines on this edge |
| ext0Req | input | 1 | External request 0 |
| tmr0Req | input | 1 | Timer 0 overflow request |
| ext1Req | input | 1 | External request 1 |
| tmr1Req | input | 1 | Timer 1 overflow request |
| serRxReq | input | 1 | Serial receive flag |
| serTxReq | input | 1 | Serial transmit flag |
| retiStb | input | 1 | Return-from-interrupt pulse |
| sfrAddr | input | 8 | Register address |
| sfrWrEn | input | 1 | Register write strobe |
| sfrWrData | input | 8 | Register write data |
| sfrRdData | output | 8 | Register read data (combinational) |
| takeIrq | output | 1 | One-cycle take-interrupt pulse |
| vecAddr | output | 16 | Vector address of the last taken request |
| clrFlags | output | 4 | Clear strobes for external 0, timer 0, external 1, timer 1 |
| actLevel | output | 2 | Active levels: bit 1 high, bit 0 low |

## Verification
If `sampleStb` is high at edge k, the snapshot is taken at k and the result shows on `takeIrq`, `vecAddr` and `clrFlags` after edge k+1. The bench therefore drives every input at a falling edge and reads these outputs at the second falling edge after the sample. It also checks that `takeIrq` is still 0 at the first falling edge after the sample, and 0 again at the third. A register write takes effect at the next rising edge, and a read is combinational, so the bench reads back at the falling edge that follows the write. `actLevel` changes on the same edge as `takeIrq`, and one edge after `retiStb`, and the bench checks it at the falling edge that follows.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;
  localparam int NUM_VEC = 5;
  localparam int IDX_W   = $clog2(NUM_VEC);
  localparam int CLR_W   = NUM_VEC - 1;

  typedef struct packed {
    logic             capture;
    logic             grant;
    logic             grantHigh;
    logic [IDX_W-1:0] grantIdx;
  } irqStrobes_t;
endpackage

// File: rtl/irqc_datapath.sv
`timescale 1ns/1ps
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8,
  parameter logic [7:0] IE_ADDR = 8'hA8,
  parameter logic [7:0] IP_ADDR = 8'hB8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_VEC-1:0] reqRaw,
  input  logic [7:0]         sfrAddr,
  input  logic               sfrWrEn,
  input  logic [7:0]         sfrWrData,
  output logic [7:0]         sfrRdData,
  input  logic               retiStb,
  input  irqStrobes_t        strobes,
  output logic [NUM_VEC-1:0] highCand,
  output logic [NUM_VEC-1:0] lowCand,
  output logic [1:0]         actLevel,
  output logic               globalEn,
  output logic               takeIrq,
  output logic [ADDR_W-1:0]  vecAddr,
  output logic [CLR_W-1:0]   clrFlags
);
  localparam int PAD_IE = 7 - NUM_VEC;
  localparam int PAD_IP = 8 - NUM_VEC;

  logic [NUM_VEC-1:0] srcEn;
  logic [NUM_VEC-1:0] srcPrio;
  logic [NUM_VEC-1:0] reqSnap;
  logic [NUM_VEC-1:0] eligible;
  logic [1:0]         levelNext;

  // Register file written through the SFR port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      globalEn <= 1'b0;
      srcEn    <= '0;
      srcPrio  <= '0;
    end else if (sfrWrEn) begin
      if (sfrAddr == IE_ADDR) begin
        globalEn <= sfrWrData[7];
        srcEn    <= sfrWrData[NUM_VEC-1:0];
      end
      if (sfrAddr == IP_ADDR) srcPrio <= sfrWrData[NUM_VEC-1:0];
    end
  end

  always_comb begin
    sfrRdData = 8'h00;
    if (sfrAddr == IE_ADDR) sfrRdData = {globalEn, {PAD_IE{1'b0}}, srcEn};
    else if (sfrAddr == IP_ADDR) sfrRdData = {{PAD_IP{1'b0}}, srcPrio};
  end

  // Request snapshot taken at the sample point
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reqSnap <= '0;
    else if (strobes.capture) reqSnap <= reqRaw;
  end

  assign eligible = reqSnap & srcEn & {NUM_VEC{globalEn}};
  assign highCand = eligible & srcPrio;
  assign lowCand  = eligible & ~srcPrio;

  // Active level tracking: return releases the innermost level first
  always_comb begin
    levelNext = actLevel;
    if (retiStb) begin
      if (levelNext[1]) levelNext[1] = 1'b0;
      else              levelNext[0] = 1'b0;
    end
    if (strobes.grant) begin
      if (strobes.grantHigh) levelNext[1] = 1'b1;
      else                   levelNext[0] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actLevel <= 2'b00;
      takeIrq  <= 1'b0;
      vecAddr  <= '0;
    end else begin
      actLevel <= levelNext;
      takeIrq  <= strobes.grant;
      if (strobes.grant)
        vecAddr <= ADDR_W'(VEC_BASE) + ADDR_W'(strobes.grantIdx) * ADDR_W'(VEC_STRIDE);
    end
  end

  // Hardware-cleared flags: every source except the last (serial)
  for (genvar i = 0; i < CLR_W; i++) begin : g_clr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) clrFlags[i] <= 1'b0;
      else       clrFlags[i] <= strobes.grant && (strobes.grantIdx == IDX_W'(i));
    end
  end
endmodule

// File: rtl/irqc_control.sv
`timescale 1ns/1ps
module irqc_control
  import irqc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               sampleStb,
  input  logic [NUM_VEC-1:0] highCand,
  input  logic [NUM_VEC-1:0] lowCand,
  input  logic [1:0]         actLevel,
  output irqStrobes_t        strobes
);
  logic pollPend;

  function automatic logic [IDX_W-1:0] firstSet(input logic [NUM_VEC-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--) if (v[i]) r = IDX_W'(i);
    return r;
  endfunction

  // Decision happens in the cycle after the sample edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pollPend <= 1'b0;
    else       pollPend <= sampleStb;
  end

  always_comb begin
    strobes = '0;
    strobes.capture = sampleStb;
    if (pollPend && !actLevel[1]) begin
      if (|highCand) begin
        strobes.grant     = 1'b1;
        strobes.grantHigh = 1'b1;
        strobes.grantIdx  = firstSet(highCand);
      end else if (|lowCand && !actLevel[0]) begin
        strobes.grant     = 1'b1;
        strobes.grantIdx  = firstSet(lowCand);
      end
    end
  end
endmodule

// File: rtl/irq_two_level.sv
`timescale 1ns/1ps
module irq_two_level
  import irqc_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8,
  parameter logic [7:0] IE_ADDR = 8'hA8,
  parameter logic [7:0] IP_ADDR = 8'hB8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleStb,
  input  logic              ext0Req,
  input  logic              tmr0Req,
  input  logic              ext1Req,
  input  logic              tmr1Req,
  input  logic              serRxReq,
  input  logic              serTxReq,
  input  logic              retiStb,
  input  logic [7:0]        sfrAddr,
  input  logic              sfrWrEn,
  input  logic [7:0]        sfrWrData,
  output logic [7:0]        sfrRdData,
  output logic              takeIrq,
  output logic [ADDR_W-1:0] vecAddr,
  output logic [CLR_W-1:0]  clrFlags,
  output logic [1:0]        actLevel
);
  logic [NUM_VEC-1:0] reqRaw;
  logic [NUM_VEC-1:0] highCand;
  logic [NUM_VEC-1:0] lowCand;
  logic               globalEn;
  irqStrobes_t        strobes;

  assign reqRaw = {serRxReq | serTxReq, tmr1Req, ext1Req, tmr0Req, ext0Req};

  irqc_control i_control (
    .clk(clk), .rstN(rstN), .sampleStb(sampleStb),
    .highCand(highCand), .lowCand(lowCand), .actLevel(actLevel),
    .strobes(strobes)
  );

  irqc_datapath #(
    .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE),
    .IE_ADDR(IE_ADDR), .IP_ADDR(IP_ADDR)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .reqRaw(reqRaw),
    .sfrAddr(sfrAddr), .sfrWrEn(sfrWrEn), .sfrWrData(sfrWrData), .sfrRdData(sfrRdData),
    .retiStb(retiStb), .strobes(strobes),
    .highCand(highCand), .lowCand(lowCand), .actLevel(actLevel), .globalEn(globalEn),
    .takeIrq(takeIrq), .vecAddr(vecAddr), .clrFlags(clrFlags)
  );
endmodule

// File: rtl/irqc_checker.sv
`timescale 1ns/1ps
module irqc_checker
  import irqc_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             sampleStb,
  input logic             retiStb,
  input logic             globalEn,
  input logic             takeIrq,
  input logic [15:0]      vecAddr,
  input logic [CLR_W-1:0] clrFlags,
  input logic [1:0]       actLevel
);
  p_take_after_sample_r4: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> $past(sampleStb, 2));

  p_global_gate_r3: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> $past(globalEn));

  p_vec_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> (vecAddr[2:0] == 3'b011 && vecAddr <= 16'h0023));

  p_high_blocks_r7: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> !$past(actLevel[1]));

  p_reti_high_r8: assert property (@(posedge clk) disable iff (!rstN)
    (retiStb && actLevel[1]) |=> !actLevel[1]);

  p_serial_no_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (takeIrq && vecAddr == 16'h0023) |-> (clrFlags == '0));

  p_clear_with_take_r9: assert property (@(posedge clk) disable iff (!rstN)
    (clrFlags != '0) |-> (takeIrq && $onehot0(clrFlags)));

  p_vec_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !takeIrq |-> $stable(vecAddr));
endmodule

bind irq_two_level irqc_checker i_checker (
  .clk(clk), .rstN(rstN), .sampleStb(sampleStb), .retiStb(retiStb),
  .globalEn(globalEn), .takeIrq(takeIrq), .vecAddr(vecAddr),
  .clrFlags(clrFlags), .actLevel(actLevel)
);

// File: tb/test_irq_two_level.sv
`timescale 1ns/1ps
module test_irq_two_level;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleStb = 0, retiStb = 0, sfrWrEn = 0;
  logic ext0Req = 0, tmr0Req = 0, ext1Req = 0, tmr1Req = 0, serRxReq = 0, serTxReq = 0;
  logic [7:0] sfrAddr = 8'h00, sfrWrData = 8'h00, sfrRdData;
  logic takeIrq;
  logic [15:0] vecAddr;
  logic [3:0] clrFlags;
  logic [1:0] actLevel;
  int checks = 0, fails = 0;
  bit done = 0;

  irq_two_level i_irq_two_level (
    .clk(clk), .rstN(rstN), .sampleStb(sampleStb),
    .ext0Req(ext0Req), .tmr0Req(tmr0Req), .ext1Req(ext1Req), .tmr1Req(tmr1Req),
    .serRxReq(serRxReq), .serTxReq(serTxReq), .retiStb(retiStb),
    .sfrAddr(sfrAddr), .sfrWrEn(sfrWrEn), .sfrWrData(sfrWrData), .sfrRdData(sfrRdData),
    .takeIrq(takeIrq), .vecAddr(vecAddr), .clrFlags(clrFlags), .actLevel(actLevel)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sfrWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); sfrAddr = a; sfrWrData = d; sfrWrEn = 1;
    @(negedge clk); sfrWrEn = 0;
  endtask

  task automatic readCheck(input logic [7:0] a, input logic [7:0] exp, input string tag);
    sfrAddr = a; #1;
    check(sfrRdData == exp, tag, sfrRdData, exp);
  endtask

  // req order: {serTx, serRx, tmr1, ext1, tmr0, ext0}
  task automatic poll(input logic [5:0] req, output logic early, output logic got,
                      output logic [15:0] vec, output logic [3:0] clr, output logic after);
    @(negedge clk);
    {serTxReq, serRxReq, tmr1Req, ext1Req, tmr0Req, ext0Req} = req; sampleStb = 1;
    @(negedge clk);
    sampleStb = 0; early = takeIrq;
    {serTxReq, serRxReq, tmr1Req, ext1Req, tmr0Req, ext0Req} = '0;
    @(negedge clk); got = takeIrq; vec = vecAddr; clr = clrFlags;
    @(negedge clk); after = takeIrq;
  endtask

  task automatic reti();
    @(negedge clk); retiStb = 1;
    @(negedge clk); retiStb = 0;
  endtask

  task automatic expectTake(input logic [5:0] req, input logic [15:0] expVec, input logic [3:0] expClr, input string tag);
    logic e, g, a; logic [15:0] v; logic [3:0] c;
    poll(req, e, g, v, c, a);
    check(!e && g && !a, {tag, " take pulse"}, {e, g, a}, 3'b010);
    check(v == expVec, {tag, " vector"}, v, expVec);
    check(c == expClr, {tag, " clear"}, c, expClr);
  endtask

  task automatic expectNone(input logic [5:0] req, input string tag);
    logic e, g, a; logic [15:0] v; logic [3:0] c;
    poll(req, e, g, v, c, a);
    check(!e && !g && !a, {tag, " no take"}, {e, g, a}, 3'b000);
  endtask

  task automatic testReset();
    check(takeIrq == 0 && actLevel == 0, "R1 take/level", {takeIrq, actLevel}, 0);
    check(vecAddr == 0 && clrFlags == 0, "R1 vec/clr", {vecAddr, clrFlags}, 0);
    readCheck(8'hA8, 8'h00, "R1 enable reset");
    readCheck(8'hB8, 8'h00, "R1 priority reset");
  endtask

  task automatic testSfr();
    sfrWrite(8'hA8, 8'hFF); readCheck(8'hA8, 8'h9F, "R2 enable bits");
    sfrWrite(8'hB8, 8'hFF); readCheck(8'hB8, 8'h1F, "R2 priority bits");
    sfrWrite(8'h90, 8'h00); readCheck(8'h90, 8'h00, "R2 other address");
    readCheck(8'hA8, 8'h9F, "R2 enable untouched");
    readCheck(8'hB8, 8'h1F, "R2 priority untouched");
    sfrWrite(8'hB8, 8'h00);
  endtask

  task automatic testGlobal();
    sfrWrite(8'hA8, 8'h1F); expectNone(6'b111111, "R3 global off");
    sfrWrite(8'hA8, 8'h80); expectNone(6'b111111, "R3 sources off");
    sfrWrite(8'hA8, 8'h82); expectTake(6'b000011, 16'h000B, 4'b0010, "R3 only timer0");
    reti();
    check(actLevel == 0, "R8 reti low", actLevel, 0);
  endtask

  task automatic testSampling();
    sfrWrite(8'hA8, 8'h9F);
    @(negedge clk); ext0Req = 1;
    @(negedge clk); ext0Req = 0;
    expectNone(6'b000000, "R4 unsampled pulse");
    check(vecAddr == 16'h000B, "R10 vector held", vecAddr, 16'h000B);
  endtask

  task automatic testOrder();
    expectTake(6'b111111, 16'h0003, 4'b0001, "R5 all low"); reti();
    expectTake(6'b001000, 16'h001B, 4'b1000, "R5 timer1 alone"); reti();
    expectTake(6'b111100, 16'h0013, 4'b0100, "R5 ext1 over timer1"); reti();
    expectTake(6'b010000, 16'h0023, 4'b0000, "R9 serial rx"); reti();
    expectTake(6'b100000, 16'h0023, 4'b0000, "R9 serial tx"); reti();
    check(actLevel == 0, "R8 idle", actLevel, 0);
  endtask

  task automatic testPriority();
    sfrWrite(8'hB8, 8'h10);
    expectTake(6'b111111, 16'h0023, 4'b0000, "R6 serial high wins");
    check(actLevel == 2'b10, "R7 high level set", actLevel, 2'b10);
    expectNone(6'b001111, "R7 high blocks all");
    reti();
    check(actLevel == 2'b00, "R8 reti high", actLevel, 2'b00);
  endtask

  task automatic testPreempt();
    sfrWrite(8'hB8, 8'h04);
    expectTake(6'b000001, 16'h0003, 4'b0001, "R7 low entry");
    check(actLevel == 2'b01, "R7 low level", actLevel, 2'b01);
    expectNone(6'b000011, "R7 low blocks low");
    expectTake(6'b000100, 16'h0013, 4'b0100, "R7 high preempts");
    check(actLevel == 2'b11, "R7 both levels", actLevel, 2'b11);
    reti();
    check(actLevel == 2'b01, "R8 high released first", actLevel, 2'b01);
    reti();
    check(actLevel == 2'b00, "R8 low released", actLevel, 2'b00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testSfr();
    testGlobal();
    testSampling();
    testOrder();
    testPriority();
    testPreempt();
    done = 1;
  end

  initial begin
    for (int n = 0; n < 20000 && !done; n++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule